// File: doc/BRIEF.md
# Ultra DMA Data-In Burst Termination Sequencer (Host Side)

This block sits on the host end of an Ultra DMA data-in transfer. It ends a running burst on request. When the device raises its DMA request, it opens a burst by asserting the acknowledge and ready lines. It reports every data word that arrives on a strobe transition. When the host buffer logic asks for a stop, and at least one word of the burst has arrived, it negates the ready line. It then works out how many trailing words the device may still deliver, from how long ago the last strobe transition was. It counts the trailing words it accepts and flags any word beyond that allowance.

After a programmable pause it asserts STOP. From then on it treats strobe transitions as carrying no data. It waits for the device to drop its request and then for a bus turnaround delay. Next it drives the host CRC, latched at that moment, onto the data lines. It holds the CRC for a setup time, releases the acknowledge, and keeps the CRC on the bus for a hold time. After an acknowledge recovery delay it returns to idle. In idle it negates STOP and allows the register-access lines to be used again. Every delay is a parameter counted in clock cycles. All control outputs keep the cable's polarity: ready and acknowledge are active low, and STOP is active high.

Top module: `udma_stop_seq`

## Requirements
- R1: A stop request is not honoured until at least one data word of the current burst has arrived. Before that, the ready line (`hostRdyN`) stays asserted at 0.
- R2: A stop request that is sampled after a word has arrived drives `hostRdyN` to 1 on the next clock edge. It stays at 1 until the sequencer is idle again (`regAccessOk` = 1).
- R3: Let d be the number of cycles between the clock edge that sampled the last strobe transition and the edge that sampled the honoured stop request. If d <= SR_CYC, at most one trailing word is accepted; otherwise at most two. `extraCnt` reports the number of trailing words accepted. A trailing word beyond the allowance gets no `wordTake` pulse and sets `protoErr`.
- R4: `stopOut` rises exactly RP_CYC cycles after `hostRdyN` rises. It stays at 1 until idle.
- R5: Once `stopOut` is 1, strobe transitions produce no `wordTake` pulse and leave `extraCnt` and `protoErr` unchanged.
- R6: `ddOe` rises exactly ZAH_CYC cycles after the clock edge that first samples `devDmaReq` at 0 while STOP is asserted. `ddOut` then carries the `hostCrc` value latched on that edge. Otherwise `ddOut` is 0.
- R7: `dmaAckN` goes to 1 after SETUP_CYC cycles of CRC drive. `ddOe` stays at 1 for HOLD_CYC more cycles, still showing the latched CRC even if `hostCrc` changes.
- R8: `stopOut` goes to 0 and `regAccessOk` goes to 1 together, HOLD_CYC + ACK_CYC cycles after `dmaAckN` goes to 1. Until then `stopOut` and `hostRdyN` stay at 1.
- R9: In idle, `devDmaReq` = 1 starts a burst on the next edge. This drives `dmaAckN` = 0, `hostRdyN` = 0 and `regAccessOk` = 0, and clears `extraCnt` and `protoErr`.
- R10: During a burst before the stop, each strobe transition (either direction) gives a one-cycle `wordTake` pulse on the following cycle.
- R11: After reset: `dmaAckN` = 1, `hostRdyN` = 1, `stopOut` = 0, `ddOe` = 0, `regAccessOk` = 1, `wordTake` = 0, `extraCnt` = 0, `protoErr` = 0.
- R12: `protoErr` stays set through the rest of the termination. It is cleared only when the next burst starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| stopReq | input | 1 | Host buffer logic asks to end the burst |
| devStrobe | input | 1 | Device data strobe level, synchronous to clk |
| devDmaReq | input | 1 | Device DMA request, active high |
| hostCrc | input | DATA_W | Host-computed CRC of the burst |
| hostRdyN | output | 1 | Host ready, active low |
| stopOut | output | 1 | STOP to the device, active high |
| dmaAckN | output | 1 | DMA acknowledge, active low |
| ddOe | output | 1 | Host drives the data lines |
| ddOut | output | DATA_W | Value on the data lines while driven |
| regAccessOk | output | 1 | Register-access lines may be asserted |
| wordTake | output | 1 | One-cycle pulse per accepted data word |
| extraCnt | output | 2 | Trailing words accepted after the stop request |
| protoErr | output | 1 | Device sent more trailing words than allowed |

## Verification
The bench places the stop request at gaps of exactly SR_CYC and SR_CYC+1 cycles after the last strobe, the two sides of the allowance boundary. A design with an off-by-one there grants two words where one is due, and misses the error flag. It raises the stop request before any word has arrived, which a careless design would honour at once. It toggles the strobe after STOP to catch a design that still counts those transitions. It measures every turnaround delay in whole cycles, so a design that drives the CRC early, or releases the acknowledge or STOP too soon, shows up as a wrong count. It also changes the CRC input during the drive window, to catch a design that passes it through instead of latching it.

// File: rtl/udma_stop_pkg.sv
package udma_stop_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_XFER,
    ST_PAUSE,
    ST_STOPPED,
    ST_BUSWAIT,
    ST_DRIVE,
    ST_HOLD,
    ST_ACKWAIT
  } stopState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic burstClr;
    logic dataWord;
    logic extraWord;
    logic flagErr;
    logic latchLimit;
    logic loadCrc;
    logic tmrClr;
  } dpCtl_t;

  function automatic int maxCyc(int a, int b, int c, int d, int e);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    if (e > m) m = e;
    return m;
  endfunction

endpackage

// File: rtl/udma_stop_dp.sv
module udma_stop_dp
  import udma_stop_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SR_CYC = 4,
  parameter int TMR_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              devStrobe,
  input  logic [DATA_W-1:0] hostCrc,
  input  dpCtl_t            ctl,
  output logic              strobeEdge,
  output logic              gotWord,
  output logic              extraFull,
  output logic [TMR_W-1:0]  tmrVal,
  output logic              wordTake,
  output logic [1:0]        extraCnt,
  output logic              protoErr,
  output logic [DATA_W-1:0] crcReg
);

  localparam int SW = $clog2(SR_CYC + 2);
  localparam logic [SW-1:0] SINCE_SAT = SW'(SR_CYC + 1);
  localparam logic [SW:0]   SR_LIMIT  = (SW+1)'(SR_CYC);

  logic          strobePrev;
  logic [SW-1:0] sinceEdge;
  logic [SW:0]   edgeGap;
  logic          nearEdge;
  logic [1:0]    extraLimit;

  assign strobeEdge = devStrobe ^ strobePrev;
  assign edgeGap    = strobeEdge ? '0 : ((SW+1)'(sinceEdge) + (SW+1)'(1));
  assign nearEdge   = (edgeGap <= SR_LIMIT);
  assign extraFull  = (extraCnt >= extraLimit);

  // strobe history: level and saturating age of the last transition
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strobePrev <= 1'b0;
      sinceEdge  <= SINCE_SAT;
    end else begin
      strobePrev <= devStrobe;
      if (strobeEdge)
        sinceEdge <= '0;
      else if (sinceEdge != SINCE_SAT)
        sinceEdge <= sinceEdge + 1'b1;
    end
  end

  // burst bookkeeping of words and trailing-word allowance
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gotWord    <= 1'b0;
      extraCnt   <= '0;
      extraLimit <= 2'd2;
      protoErr   <= 1'b0;
      wordTake   <= 1'b0;
    end else begin
      wordTake <= ctl.dataWord | ctl.extraWord;
      if (ctl.burstClr) begin
        gotWord  <= 1'b0;
        extraCnt <= '0;
        protoErr <= 1'b0;
      end else begin
        if (ctl.dataWord)  gotWord  <= 1'b1;
        if (ctl.extraWord) extraCnt <= extraCnt + 1'b1;
        if (ctl.flagErr)   protoErr <= 1'b1;
      end
      if (ctl.latchLimit)
        extraLimit <= nearEdge ? 2'd1 : 2'd2;
    end
  end

  // shared phase timer and CRC holding register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmrVal <= '0;
      crcReg <= '0;
    end else begin
      tmrVal <= ctl.tmrClr ? '0 : tmrVal + 1'b1;
      if (ctl.loadCrc) crcReg <= hostCrc;
    end
  end

endmodule

// File: rtl/udma_stop_ctl.sv
module udma_stop_ctl
  import udma_stop_pkg::*;
#(
  parameter int RP_CYC    = 3,
  parameter int ZAH_CYC   = 2,
  parameter int SETUP_CYC = 2,
  parameter int HOLD_CYC  = 1,
  parameter int ACK_CYC   = 3,
  parameter int TMR_W     = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             stopReq,
  input  logic             devDmaReq,
  input  logic             strobeEdge,
  input  logic             gotWord,
  input  logic             extraFull,
  input  logic [TMR_W-1:0] tmrVal,
  output dpCtl_t           ctl,
  output logic             hostRdyN,
  output logic             stopOut,
  output logic             dmaAckN,
  output logic             ddOe,
  output logic             regAccessOk
);

  localparam logic [TMR_W-1:0] RP_LAST    = TMR_W'(RP_CYC - 1);
  localparam logic [TMR_W-1:0] ZAH_LAST   = TMR_W'(ZAH_CYC - 1);
  localparam logic [TMR_W-1:0] SETUP_LAST = TMR_W'(SETUP_CYC - 1);
  localparam logic [TMR_W-1:0] HOLD_LAST  = TMR_W'(HOLD_CYC - 1);
  localparam logic [TMR_W-1:0] ACK_LAST   = TMR_W'(ACK_CYC - 1);

  stopState_t state, nxtState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxtState;
  end

  always_comb begin
    nxtState = state;
    ctl      = '0;
    unique case (state)
      ST_IDLE: begin
        if (devDmaReq) begin
          nxtState     = ST_XFER;
          ctl.burstClr = 1'b1;
        end
      end
      ST_XFER: begin
        ctl.dataWord = strobeEdge;
        if (stopReq && gotWord) begin
          nxtState       = ST_PAUSE;
          ctl.latchLimit = 1'b1;
          ctl.tmrClr     = 1'b1;
        end
      end
      ST_PAUSE: begin
        ctl.extraWord = strobeEdge && !extraFull;
        ctl.flagErr   = strobeEdge && extraFull;
        if (tmrVal == RP_LAST) begin
          nxtState   = ST_STOPPED;
          ctl.tmrClr = 1'b1;
        end
      end
      ST_STOPPED: begin
        if (!devDmaReq) begin
          nxtState   = ST_BUSWAIT;
          ctl.tmrClr = 1'b1;
        end
      end
      ST_BUSWAIT: begin
        if (tmrVal == ZAH_LAST) begin
          nxtState    = ST_DRIVE;
          ctl.tmrClr  = 1'b1;
          ctl.loadCrc = 1'b1;
        end
      end
      ST_DRIVE: begin
        if (tmrVal == SETUP_LAST) begin
          nxtState   = ST_HOLD;
          ctl.tmrClr = 1'b1;
        end
      end
      ST_HOLD: begin
        if (tmrVal == HOLD_LAST) begin
          nxtState   = ST_ACKWAIT;
          ctl.tmrClr = 1'b1;
        end
      end
      ST_ACKWAIT: begin
        if (tmrVal == ACK_LAST) begin
          nxtState   = ST_IDLE;
          ctl.tmrClr = 1'b1;
        end
      end
      default: nxtState = ST_IDLE;
    endcase
  end

  assign hostRdyN    = (state != ST_XFER);
  assign regAccessOk = (state == ST_IDLE);
  assign dmaAckN     = (state == ST_IDLE) || (state == ST_HOLD) || (state == ST_ACKWAIT);
  assign ddOe        = (state == ST_DRIVE) || (state == ST_HOLD);
  assign stopOut     = (state == ST_STOPPED) || (state == ST_BUSWAIT) || (state == ST_DRIVE)
                    || (state == ST_HOLD) || (state == ST_ACKWAIT);

endmodule

// File: rtl/udma_stop_seq.sv
module udma_stop_seq
  import udma_stop_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int SR_CYC    = 4,
  parameter int RP_CYC    = 3,
  parameter int ZAH_CYC   = 2,
  parameter int SETUP_CYC = 2,
  parameter int HOLD_CYC  = 1,
  parameter int ACK_CYC   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stopReq,
  input  logic              devStrobe,
  input  logic              devDmaReq,
  input  logic [DATA_W-1:0] hostCrc,
  output logic              hostRdyN,
  output logic              stopOut,
  output logic              dmaAckN,
  output logic              ddOe,
  output logic [DATA_W-1:0] ddOut,
  output logic              regAccessOk,
  output logic              wordTake,
  output logic [1:0]        extraCnt,
  output logic              protoErr
);

  localparam int MAX_CYC = maxCyc(RP_CYC, ZAH_CYC, SETUP_CYC, HOLD_CYC, ACK_CYC);
  localparam int TMR_W   = $clog2(MAX_CYC + 1);

  dpCtl_t            ctl;
  logic              strobeEdge;
  logic              gotWord;
  logic              extraFull;
  logic [TMR_W-1:0]  tmrVal;
  logic [DATA_W-1:0] crcReg;

  udma_stop_ctl #(
    .RP_CYC(RP_CYC), .ZAH_CYC(ZAH_CYC), .SETUP_CYC(SETUP_CYC),
    .HOLD_CYC(HOLD_CYC), .ACK_CYC(ACK_CYC), .TMR_W(TMR_W)
  ) ctlU (
    .clk(clk), .rstN(rstN), .stopReq(stopReq), .devDmaReq(devDmaReq),
    .strobeEdge(strobeEdge), .gotWord(gotWord), .extraFull(extraFull),
    .tmrVal(tmrVal), .ctl(ctl), .hostRdyN(hostRdyN), .stopOut(stopOut),
    .dmaAckN(dmaAckN), .ddOe(ddOe), .regAccessOk(regAccessOk)
  );

  udma_stop_dp #(
    .DATA_W(DATA_W), .SR_CYC(SR_CYC), .TMR_W(TMR_W)
  ) dpU (
    .clk(clk), .rstN(rstN), .devStrobe(devStrobe), .hostCrc(hostCrc),
    .ctl(ctl), .strobeEdge(strobeEdge), .gotWord(gotWord),
    .extraFull(extraFull), .tmrVal(tmrVal), .wordTake(wordTake),
    .extraCnt(extraCnt), .protoErr(protoErr), .crcReg(crcReg)
  );

  assign ddOut = ddOe ? crcReg : '0;

endmodule

// File: rtl/udma_stop_chk.sv
module udma_stop_chk (
  input logic       clk,
  input logic       rstN,
  input logic       devDmaReq,
  input logic       hostRdyN,
  input logic       stopOut,
  input logic       dmaAckN,
  input logic       ddOe,
  input logic       regAccessOk,
  input logic       wordTake,
  input logic [1:0] extraCnt,
  input logic       protoErr
);

  // R2
  rdy_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostRdyN && !regAccessOk) |=> (hostRdyN || regAccessOk));

  // R4
  stop_after_rdy_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stopOut) |-> (hostRdyN && $past(hostRdyN)));

  // R5
  no_data_after_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stopOut && $past(stopOut)) |-> !wordTake);

  // R6
  drive_after_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    ddOe |-> (!devDmaReq && stopOut && hostRdyN));

  // R7
  ack_release_while_driven_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dmaAckN) |-> ddOe);

  // R8
  reg_access_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    regAccessOk |-> (dmaAckN && !ddOe && !stopOut));

  // R3
  extra_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    extraCnt <= 2'd2);

  // R12
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (protoErr && !regAccessOk) |=> protoErr);

endmodule

bind udma_stop_seq udma_stop_chk chkU (
  .clk(clk), .rstN(rstN), .devDmaReq(devDmaReq), .hostRdyN(hostRdyN),
  .stopOut(stopOut), .dmaAckN(dmaAckN), .ddOe(ddOe),
  .regAccessOk(regAccessOk), .wordTake(wordTake), .extraCnt(extraCnt),
  .protoErr(protoErr)
);

// File: tb/tb_udma_stop_seq.sv
module tb_udma_stop_seq;

  localparam int DW    = 16;
  localparam int SR    = 4;
  localparam int RP    = 3;
  localparam int ZAH   = 2;
  localparam int SETUP = 2;
  localparam int HOLD  = 1;
  localparam int ACK   = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stopReq = 1'b0;
  logic devStrobe = 1'b0;
  logic devDmaReq = 1'b0;
  logic [DW-1:0] hostCrc = '0;
  logic hostRdyN, stopOut, dmaAckN, ddOe, regAccessOk, wordTake, protoErr;
  logic [DW-1:0] ddOut;
  logic [1:0] extraCnt;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [DW-1:0] crc;
    int            extra;
    bit            err;
  } sbItem_t;
  sbItem_t sbq[$];

  always #2.5 clk = ~clk;

  udma_stop_seq #(
    .DATA_W(DW), .SR_CYC(SR), .RP_CYC(RP), .ZAH_CYC(ZAH),
    .SETUP_CYC(SETUP), .HOLD_CYC(HOLD), .ACK_CYC(ACK)
  ) dut (
    .clk(clk), .rstN(rstN), .stopReq(stopReq), .devStrobe(devStrobe),
    .devDmaReq(devDmaReq), .hostCrc(hostCrc), .hostRdyN(hostRdyN),
    .stopOut(stopOut), .dmaAckN(dmaAckN), .ddOe(ddOe), .ddOut(ddOut),
    .regAccessOk(regAccessOk), .wordTake(wordTake), .extraCnt(extraCnt),
    .protoErr(protoErr)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: on the first cycle of CRC drive, pop and compare the scoreboard item
  logic oePrev = 1'b0;
  always @(negedge clk) begin
    if (rstN && ddOe && !oePrev) begin
      if (sbq.size() == 0) begin
        check(1'b0, "R6 unexpected CRC drive", 1, 0);
      end else begin
        sbItem_t it;
        it = sbq.pop_front();
        check(ddOut == it.crc, "R6 CRC value on bus", int'(ddOut), int'(it.crc));
        check(int'(extraCnt) == it.extra, "R3 trailing word count", int'(extraCnt), it.extra);
        check(protoErr == it.err, "R12 error flag at drive", int'(protoErr), int'(it.err));
      end
    end
    oePrev <= ddOe;
  end

  task automatic runBurst(input bit early, input int nWords, input int gap, input int nExtra,
                          input int postEdges, input logic [DW-1:0] crc,
                          input int expExtra, input bit expErr);
    int acc;
    int k;
    int kOe;
    int badHold;
    sbq.push_back('{crc, expExtra, expErr});
    hostCrc   = crc;
    devDmaReq = 1'b1;
    if (early) stopReq = 1'b1;
    @(negedge clk);
    check(dmaAckN == 0 && hostRdyN == 0 && regAccessOk == 0, "R9 burst start lines",
          int'({dmaAckN, hostRdyN, regAccessOk}), 0);
    check(protoErr == 0 && extraCnt == 0, "R9 R12 flags cleared at start",
          int'({protoErr, extraCnt}), 0);
    if (early) begin
      repeat (3) @(negedge clk);
      check(hostRdyN == 0, "R1 stop before any word ignored", int'(hostRdyN), 0);
    end
    for (int i = 0; i < nWords; i++) begin
      devStrobe = ~devStrobe;
      @(negedge clk);
      check(wordTake == 1, "R10 data word pulse", int'(wordTake), 1);
    end
    repeat (gap - 1) @(negedge clk);
    stopReq = 1'b1;
    @(negedge clk);
    check(hostRdyN == 1, "R2 ready negated after stop request", int'(hostRdyN), 1);
    stopReq = 1'b0;
    acc = 0;
    k = 1;
    while (k < 40) begin
      if (k > 1) acc += int'(wordTake);
      if (stopOut) break;
      check(hostRdyN == 1, "R2 ready held during pause", int'(hostRdyN), 1);
      if (k <= nExtra) devStrobe = ~devStrobe;
      @(negedge clk);
      k++;
    end
    check(k == RP + 1, "R4 STOP delay after ready negation", k - 1, RP);
    check(acc == expExtra, "R3 trailing word pulses", acc, expExtra);
    check(int'(extraCnt) == expExtra, "R3 extraCnt", int'(extraCnt), expExtra);
    check(protoErr == expErr, "R3 protoErr", int'(protoErr), int'(expErr));
    for (int i = 0; i < postEdges; i++) begin
      devStrobe = ~devStrobe;
      @(negedge clk);
      check(wordTake == 0, "R5 strobe after STOP carries no data", int'(wordTake), 0);
    end
    @(negedge clk);
    check(int'(extraCnt) == expExtra && protoErr == expErr, "R5 counters untouched after STOP",
          int'({protoErr, extraCnt}), int'({expErr, 2'(expExtra)}));
    devDmaReq = 1'b0;
    k = 0;
    do begin
      @(negedge clk);
      k++;
      if (!ddOe) check(ddOut == 0, "R6 bus idle before turnaround", int'(ddOut), 0);
    end while (!ddOe && k < 40);
    check(k == ZAH + 1, "R6 turnaround before CRC drive", k - 1, ZAH);
    check(dmaAckN == 0 && stopOut == 1, "R6 ack held while driving",
          int'({dmaAckN, stopOut}), 1);
    hostCrc = ~crc;
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!dmaAckN && k < 40);
    check(k == SETUP, "R7 CRC setup before ack release", k, SETUP);
    check(ddOe == 1 && ddOut == crc, "R7 CRC still driven at ack release", int'(ddOut), int'(crc));
    k = 0;
    kOe = -1;
    badHold = 0;
    do begin
      if (!(stopOut && hostRdyN)) badHold++;
      @(negedge clk);
      k++;
      if (!ddOe && kOe < 0) kOe = k;
    end while (!regAccessOk && k < 40);
    check(kOe == HOLD, "R7 CRC hold after ack release", kOe, HOLD);
    check(k == HOLD + ACK, "R8 ack recovery before register access", k, HOLD + ACK);
    check(badHold == 0, "R8 STOP and ready held until recovery ends", badHold, 0);
    check(stopOut == 0 && ddOe == 0, "R8 STOP negated at end", int'({stopOut, ddOe}), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(dmaAckN == 1 && hostRdyN == 1 && stopOut == 0 && ddOe == 0 && regAccessOk == 1
          && wordTake == 0 && extraCnt == 0 && protoErr == 0, "R11 reset state",
          int'({dmaAckN, hostRdyN, stopOut, ddOe, regAccessOk}), 5'b11001);
    rstN = 1'b1;
    @(negedge clk);
    check(regAccessOk == 1 && dmaAckN == 1, "R11 idle after reset",
          int'({regAccessOk, dmaAckN}), 3);
    // early request: one word, allowance one, one trailing word
    runBurst(1'b1, 1, 1, 1, 2, 16'hA5C3, 1, 1'b0);
    // gap exactly SR: allowance one, two sent -> error
    runBurst(1'b0, 4, SR, 2, 1, 16'h1234, 1, 1'b1);
    check(protoErr == 1, "R12 error kept in idle", int'(protoErr), 1);
    // gap SR+1: allowance two, two sent, error cleared by new burst
    runBurst(1'b0, 3, SR + 1, 2, 3, 16'hBEEF, 2, 1'b0);
    // long gap: allowance two, three sent -> error
    runBurst(1'b0, 2, 8, 3, 0, 16'h0F0F, 2, 1'b1);
    // no trailing words
    runBurst(1'b0, 5, 2, 0, 1, 16'hFFFF, 0, 1'b0);
    check(sbq.size() == 0, "R6 every burst drove its CRC", sbq.size(), 0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule